// File: doc/BRIEF.md
# Serial Control and Status Port

This block is a synchronous serial slave that connects a host to a telephony tone transceiver core. It uses four wires: a commit strobe, a shift clock, one data line split into an input and a driven output with its own enable, and a direction select. In the write direction, the host clocks a 14-bit control word into a shadow register. While the strobe is high, that word is applied to the active control fields. In the read direction, the rising edge of the strobe captures the 4-bit digit code from the tone decoder. The block shows bit 0 at once and then shifts out the higher bits, one per clock.

All four serial inputs come from outside the system clock domain. Each one passes through a two-flop synchronizer, and edges are found on the synchronized copies. The active fields feed the rest of the transceiver: operating mode, transmit squelch, detect-time select, attenuation/gain code and tone code. These fields are registered and change only while a commit is in progress.

Top module: `ctrl_serial_port`

## Requirements
- R1: After reset, every active control field is zero (mode 000 = receive), `ser_data_oe` is 0 and `ser_data_o` is 0.
- R2: With direction low (0 = write), each rising shift clock moves the data input into the shadow register, first bit deepest. After 14 clocks, the first bit is the tone code MSB. The fields are packed from first-sent to last-sent as tone[3:0], atten[3:0], det_time[1:0], squelch, mode[2:0].
- R3: While direction is low and the strobe is high, the active fields take the shadow value. While the strobe is low, they hold their last value, even if new bits are shifted in.
- R4: With direction high (1 = read), a rising strobe captures `digit_i`. The block drives digit bit 0 on `ser_data_o` and sets `ser_data_oe` to 1 before any shift clock arrives.
- R5: In a read, the next three rising shift clocks present digit bits 1, 2 and 3 in turn. Later clocks keep bit 3 on the line. A change of `digit_i` after capture is not seen until the next strobe.
- R6: While direction is low, `ser_data_oe` is 0 and `ser_data_o` is 0. A captured digit is discarded.
- R7: Mode codes 000 to 101 are applied unchanged. The codes 110 and 111 are applied as 000 (receive).
- R8: A write of fewer or more than 14 clocks commits the last 14 bits shifted in. Shorter writes keep the older shadow bits in the upper positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_en_i | input | 1 | Commit / capture strobe |
| ser_dir_i | input | 1 | Direction: 0 write, 1 read |
| ser_data_i | input | 1 | Serial data from the pad |
| digit_i | input | 4 | Decoded digit code from the tone decoder |
| ser_data_o | output | 1 | Serial read data to the pad |
| ser_data_oe | output | 1 | Pad driver enable |
| mode_o | output | 3 | Active operating mode |
| squelch_o | output | 1 | Active transmit squelch |
| det_time_o | output | 2 | Active detect-time select |
| atten_o | output | 4 | Active attenuation / gain code |
| tone_o | output | 4 | Active tone code |

## Verification
A shadow register that shifts the wrong way or slips a bit shows up as misplaced fields. This is seen three system clocks after the commit strobe rises. A read index that is off by one puts the wrong digit bit on the line three clocks after the shift clock edge. A stale direction or capture state shows as the driver enable staying asserted after a return to write, or as a new `digit_i` leaking onto the line between strobes. The bench checks each of these at the ports, in the cycle the two synchronizer flops and the output register allow.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int TONE_W = 4;
  localparam int ATT_W  = 4;
  localparam int DET_W  = 2;
  localparam int MODE_W = 3;
  localparam int CTRL_W = TONE_W + ATT_W + DET_W + 1 + MODE_W;

  typedef enum logic [MODE_W-1:0] {
    MODE_RX      = 3'd0,
    MODE_TONE_TX = 3'd1,
    MODE_SINGLE  = 3'd2,
    MODE_SLEEP_A = 3'd3,
    MODE_SLEEP_B = 3'd4,
    MODE_LOOP    = 3'd5
  } op_mode_e;

  // first-sent bit lands in the MSB (tone), last-sent in the LSB (mode)
  typedef struct packed {
    logic [TONE_W-1:0] tone;
    logic [ATT_W-1:0]  atten;
    logic [DET_W-1:0]  det;
    logic              sq;
    logic [MODE_W-1:0] mode;
  } ctrl_word_t;

  function automatic logic [MODE_W-1:0] legal_mode(input logic [MODE_W-1:0] m);
    legal_mode = (m > MODE_LOOP) ? MODE_RX : m;
  endfunction
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0] chain [WIDTH];

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= '0;
      else     chain[g] <= {chain[g][STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[g][STAGES-1];
  end
endmodule

// File: rtl/ssp_wr_path.sv
module ssp_wr_path
  import ssp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       shift_i,
  input  logic       bit_i,
  input  logic       commit_i,
  output ctrl_word_t shadow_o,
  output ctrl_word_t active_o
);
  logic [CTRL_W-1:0] shadow_q;
  ctrl_word_t        active_q;
  ctrl_word_t        shadow_s;

  assign shadow_s = ctrl_word_t'(shadow_q);

  always_ff @(posedge clk) begin
    if (rst)          shadow_q <= '0;
    else if (shift_i) shadow_q <= {shadow_q[CTRL_W-2:0], bit_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
    end else if (commit_i) begin
      active_q      <= shadow_s;
      active_q.mode <= legal_mode(shadow_s.mode);
    end
  end

  assign shadow_o = shadow_s;
  assign active_o = active_q;
endmodule

// File: rtl/ssp_rd_path.sv
module ssp_rd_path #(
  parameter int DIG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_sel_i,
  input  logic             capture_i,
  input  logic             shift_i,
  input  logic [DIG_W-1:0] digit_i,
  output logic             dout_o,
  output logic             oe_o
);
  localparam int IDX_W = (DIG_W > 1) ? $clog2(DIG_W) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DIG_W - 1);

  logic [DIG_W-1:0] stat_q;
  logic [IDX_W-1:0] idx_q;
  logic             dout_q, oe_q;

  always_ff @(posedge clk) begin
    if (rst || !rd_sel_i) begin
      stat_q <= '0;
      idx_q  <= '0;
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (capture_i) begin
      stat_q <= digit_i;
      idx_q  <= '0;
      dout_q <= digit_i[0];
      oe_q   <= 1'b1;
    end else if (shift_i && oe_q && idx_q != LAST) begin
      idx_q  <= idx_q + 1'b1;
      dout_q <= stat_q[idx_q + 1'b1];
    end
  end

  assign dout_o = dout_q;
  assign oe_o   = oe_q;
endmodule

// File: rtl/ctrl_serial_port.sv
module ctrl_serial_port
  import ssp_pkg::*;
#(
  parameter int DIG_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_en_i,
  input  logic              ser_dir_i,
  input  logic              ser_data_i,
  input  logic [DIG_W-1:0]  digit_i,
  output logic              ser_data_o,
  output logic              ser_data_oe,
  output logic [MODE_W-1:0] mode_o,
  output logic              squelch_o,
  output logic [DET_W-1:0]  det_time_o,
  output logic [ATT_W-1:0]  atten_o,
  output logic [TONE_W-1:0] tone_o
);
  logic [3:0] sync_q;
  logic       clk_s, en_s, dir_s, dat_s;
  logic       clk_d, en_d;
  logic       clk_rise, en_rise;
  ctrl_word_t shadow, active;

  ssp_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({ser_clk_i, ser_en_i, ser_dir_i, ser_data_i}),
    .q_o (sync_q)
  );
  assign {clk_s, en_s, dir_s, dat_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_d <= 1'b0;
      en_d  <= 1'b0;
    end else begin
      clk_d <= clk_s;
      en_d  <= en_s;
    end
  end
  assign clk_rise = clk_s & ~clk_d;
  assign en_rise  = en_s & ~en_d;

  ssp_wr_path u_wr (
    .clk      (clk),
    .rst      (rst),
    .shift_i  (clk_rise & ~dir_s),
    .bit_i    (dat_s),
    .commit_i (en_s & ~dir_s),
    .shadow_o (shadow),
    .active_o (active)
  );

  ssp_rd_path #(.DIG_W(DIG_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_sel_i  (dir_s),
    .capture_i (en_rise),
    .shift_i   (clk_rise),
    .digit_i   (digit_i),
    .dout_o    (ser_data_o),
    .oe_o      (ser_data_oe)
  );

  assign mode_o     = active.mode;
  assign squelch_o  = active.sq;
  assign det_time_o = active.det;
  assign atten_o    = active.atten;
  assign tone_o     = active.tone;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker
  import ssp_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              dir_s,
  input logic              en_s,
  input ctrl_word_t        shadow,
  input logic              ser_data_o,
  input logic              ser_data_oe,
  input logic [MODE_W-1:0] mode_o,
  input logic              squelch_o,
  input logic [DET_W-1:0]  det_time_o,
  input logic [ATT_W-1:0]  atten_o,
  input logic [TONE_W-1:0] tone_o
);
  a_r6_driver_off: assert property (@(posedge clk) disable iff (rst)
    !dir_s |=> (!ser_data_oe && !ser_data_o));

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !(en_s && !dir_s) |=> ($stable(tone_o) && $stable(atten_o) && $stable(det_time_o)
                           && $stable(squelch_o) && $stable(mode_o)));

  a_r3_commit_fields: assert property (@(posedge clk) disable iff (rst)
    (en_s && !dir_s) |=> ({tone_o, atten_o, det_time_o, squelch_o} ==
                          $past({shadow.tone, shadow.atten, shadow.det, shadow.sq})));

  a_r7_mode_legal: assert property (@(posedge clk) disable iff (rst)
    mode_o <= MODE_LOOP);

  a_r4_oe_kept_in_read: assert property (@(posedge clk) disable iff (rst)
    (ser_data_oe && dir_s) |=> ser_data_oe);
endmodule

bind ctrl_serial_port ssp_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .dir_s       (dir_s),
  .en_s        (en_s),
  .shadow      (shadow),
  .ser_data_o  (ser_data_o),
  .ser_data_oe (ser_data_oe),
  .mode_o      (mode_o),
  .squelch_o   (squelch_o),
  .det_time_o  (det_time_o),
  .atten_o     (atten_o),
  .tone_o      (tone_o)
);

// File: tb/ctrl_serial_port_test.sv
module ctrl_serial_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;
  // {tone, atten, det, sq, mode, digit}
  localparam logic [17:0] VEC [NVEC] = '{
    {4'h5, 4'h3, 2'b01, 1'b0, 3'b001, 4'hA},
    {4'hF, 4'hE, 2'b11, 1'b1, 3'b101, 4'h5},
    {4'h0, 4'h9, 2'b10, 1'b0, 3'b010, 4'hC},
    {4'h3, 4'h0, 2'b00, 1'b1, 3'b111, 4'h3}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic ser_clk = 0, ser_en = 0, ser_dir = 0, ser_din = 0;
  logic [3:0] digit = 0;
  logic ser_dout, ser_oe, sq;
  logic [2:0] mode;
  logic [1:0] det;
  logic [3:0] att, tone;
  logic [13:0] sh = '0;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_serial_port uut (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_en_i(ser_en),
    .ser_dir_i(ser_dir), .ser_data_i(ser_din), .digit_i(digit),
    .ser_data_o(ser_dout), .ser_data_oe(ser_oe), .mode_o(mode),
    .squelch_o(sq), .det_time_o(det), .atten_o(att), .tone_o(tone)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    ser_dir = 0; ser_en = 0;
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = v[i]; step();
      ser_clk = 1; step();
      ser_clk = 0; step();
      sh = {sh[12:0], v[i]};
    end
  endtask

  task automatic commit();
    ser_en = 1; step(); step();
    ser_en = 0; step();
  endtask

  function automatic logic [2:0] exp_mode(input logic [2:0] m);
    return (m > 3'd5) ? 3'd0 : m;
  endfunction

  task automatic chk_fields(input string tag, input logic [13:0] w);
    chk({tag, " R2 tone"}, 16'(tone), 16'(w[13:10]));
    chk({tag, " R2 atten"}, 16'(att), 16'(w[9:6]));
    chk({tag, " R2 det"}, 16'(det), 16'(w[5:4]));
    chk({tag, " R2 squelch"}, 16'(sq), 16'(w[3]));
    chk({tag, " R7 mode"}, 16'(mode), 16'(exp_mode(w[2:0])));
  endtask

  task automatic do_read(input logic [3:0] d);
    digit = d; ser_dir = 1; step();
    ser_en = 1; step();
    chk("R4 oe after strobe", 16'(ser_oe), 16'd1);
    chk("R4 bit0", 16'(ser_dout), 16'(d[0]));
    ser_en = 0; step();
    for (int k = 1; k < 4; k++) begin
      ser_clk = 1; step();
      chk("R5 shifted bit", 16'(ser_dout), 16'(d[k]));
      ser_clk = 0; step();
    end
    ser_clk = 1; step(); ser_clk = 0; step();
    chk("R5 hold bit3 after extra clock", 16'(ser_dout), 16'(d[3]));
    digit = ~d; step();
    chk("R5 new digit not seen", 16'(ser_dout), 16'(d[3]));
    ser_dir = 0; step();
    chk("R6 oe off in write", 16'(ser_oe), 16'd0);
    chk("R6 data zero in write", 16'(ser_dout), 16'd0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    rst = 0;
    @(negedge clk);
    chk_fields("R1 reset", 14'd0);
    chk("R1 oe reset", 16'(ser_oe), 16'd0);
    chk("R1 data reset", 16'(ser_dout), 16'd0);

    for (int v = 0; v < NVEC; v++) begin
      send_bits(16'(VEC[v][17:4]), 14);
      commit();
      chk_fields("R3 vector commit", VEC[v][17:4]);
      do_read(VEC[v][3:0]);
    end

    // R3: shifting without a strobe leaves the active fields alone
    send_bits(16'h2A5C, 14);
    chk_fields("R3 hold without strobe", VEC[NVEC-1][17:4]);
    commit();
    chk_fields("R3 commit after hold", sh);

    // R8: short and long writes
    send_bits(16'h0155, 10);
    commit();
    chk_fields("R8 short write", sh);
    send_bits(16'hB3C9, 16);
    commit();
    chk_fields("R8 long write", sh);

    // R6: read then return low discards data; a fresh read uses the new digit
    do_read(4'h6);
    do_read(4'h9);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule